// File: doc/BRIEF.md
# E1 Timeslot-Zero Transmit Generator

This block builds the timeslot-zero byte of every frame in a 16-frame CRC-4 multiframe on an E1 (PCM-30) link and shifts it out one bit per bit strobe, most significant bit first. Even frames carry the alignment word: a CRC-4 bit followed by a fixed seven-bit tail. Odd frames carry the non-alignment word. That word holds a multiframe-alignment or far-end-error bit, a constant one, the remote-alarm bit, and five national (Sa) bits.

The surrounding framer supplies the frame number, a strobe that marks bit 1 of timeslot zero, the four CRC-4 bits of the current submultiframe, the remote-alarm bit and the two error-indication bits. A host writes the national bits into a transposed buffer. The buffer has one byte per Sa bit, and each byte holds one bit for each odd frame. A write is staged and becomes visible only at the next multiframe boundary. An active-low transmit-AIS input forces an all-ones line from power-up onwards. After a hardware or software reset, the block stays quiet for one full frame of bit strobes before it produces any bytes.

Top module: `e1ts0_tx_gen`

## Requirements
- R1: In an even frame f, the byte is {C, 0,0,1,1,0,1,1}. C is crc_bits[3-((f/2) mod 4)], so crc_bits[3] is C1 and is used in frames 0 and 8, and crc_bits[0] is C4 and is used in frames 6 and 14.
- R2: A bit strobe with ts0_start high loads the byte. After that clock edge, ser_out shows bit 1 (the MSB), and each of the next seven strobes advances one bit. ts0_valid is high for exactly these eight bit periods.
- R3: ser_out and ts0_valid change only on clock edges that carry a bit strobe (resets aside). When no byte is being sent, ser_out is 1 and ts0_valid is 0.
- R4: In an odd frame f, let k = (f-1)/2. The byte then has bit 2 = 1 and bit 3 = a_bit. Bits 4 to 8 are Sa4..Sa8, where Sa(4+j) is bit (7-k) of buffer byte j.
- R5: Bit 1 of odd frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 in that order. Bit 1 of frame 13 is e_bits[1] (E1), and bit 1 of frame 15 is e_bits[0] (E2).
- R6: nb_wr_sel values 0 to 4 select the buffer bytes for Sa4 to Sa8. A write with nb_wr_sel of 5, 6 or 7 changes nothing.
- R7: A buffer write takes effect only at the next byte load for frame 0. Odd frames later in the same multiframe still carry the previous contents.
- R8: While ais_n is low, ser_out is 1, during reset as well. Normal output resumes as soon as ais_n goes high.
- R9: After rst_n is released or soft_rst is pulsed, init_busy stays high for FRAME_BITS bit strobes. During that time ts0_start is ignored, ts0_valid is 0 and ser_out is 1.
- R10: Both rst_n and soft_rst return every national-bit buffer byte, staged and in use, to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | One-cycle software reset request |
| bit_en | input | 1 | Line bit strobe |
| ts0_start | input | 1 | Marks the strobe of timeslot-zero bit 1 |
| frame_idx | input | 4 | Frame number in the multiframe, 0..15 |
| crc_bits | input | 4 | C1..C4 of the current submultiframe, C1 in bit 3 |
| a_bit | input | 1 | Remote-alarm bit |
| e_bits | input | 2 | E1 in bit 1, E2 in bit 0 |
| nb_wr_en | input | 1 | National-bit buffer write enable |
| nb_wr_sel | input | 3 | Buffer byte select, 0..4 = Sa4..Sa8 |
| nb_wr_data | input | 8 | Buffer byte, MSB = odd frame 1 |
| ais_n | input | 1 | Active-low transmit-AIS override |
| ser_out | output | 1 | Serial timeslot-zero data |
| ts0_valid | output | 1 | High while a timeslot-zero bit is on ser_out |
| init_busy | output | 1 | High during the one-frame reset period |

## Verification
If the CRC select is wrong, bit 1 of the alignment word shows the wrong CRC bit within one frame. If the odd-frame index is off, the multiframe pattern and the Sa bits shift, and this is visible in the next non-alignment byte. If the commit logic for the staged buffer is wrong, the new Sa values show up before frame 0, or never. That is detected within two multiframes, because a write is followed by odd frames of the same multiframe and then by the next multiframe. If the reset timer is wrong, bytes appear one strobe early or late around the end of the first frame. If the serializer loses its bit count, ts0_valid runs longer or shorter than eight strobes, and this is seen in the very next byte.

// File: rtl/e1ts0_pkg.sv
// Package: shared constants and types for the E1 timeslot-zero generator.
// Assumes a 16-frame multiframe, 8-bit timeslot and five national bits.
package e1ts0_pkg;
    localparam int TS_BITS     = 8;
    localparam int FRAMES_MF   = 16;
    localparam int FIDX_W      = $clog2(FRAMES_MF);
    localparam int ODD_FRAMES  = FRAMES_MF / 2;
    localparam int SA_COUNT    = 5;
    localparam int SEL_W       = $clog2(SA_COUNT);

    // Fixed seven-bit tail of the alignment word (bits 2..8).
    localparam logic [6:0] ALIGN_TAIL = 7'b0011011;
    // Bit 1 of odd frames indexed by k = (f-1)/2, MSB = k0; k6/k7 are E bits.
    localparam logic [ODD_FRAMES-1:0] ODD_B1_LUT = 8'b0010_1100;

    typedef logic [TS_BITS-1:0] ts_byte_t;
    typedef logic [SA_COUNT-1:0][ODD_FRAMES-1:0] sa_bank_t;
    typedef enum logic {WORD_ALIGN = 1'b0, WORD_NONALIGN = 1'b1} word_kind_e;
endpackage

// File: rtl/e1ts0_natbuf.sv
// National-bit buffer: host-written staged bank plus an in-use bank.
// The staged bank is copied into the in-use bank on commit (multiframe
// boundary). Selects at or above SA_COUNT are ignored. Both banks return
// to RST_VAL on reset or soft reset.
module e1ts0_natbuf
    import e1ts0_pkg::*;
#(
    parameter logic [ODD_FRAMES-1:0] RST_VAL = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [ODD_FRAMES-1:0] wr_data,
    input  logic                  commit,
    output sa_bank_t              active
);
    sa_bank_t staged_q;
    sa_bank_t active_q;

    for (genvar j = 0; j < SA_COUNT; j++) begin : g_lane
        // Capture a host write into the staged byte of this Sa lane.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                staged_q[j] <= RST_VAL;
            else if (wr_en && wr_sel == SEL_W'(j))
                staged_q[j] <= wr_data;
        end

        // Promote the staged byte into use at the multiframe boundary.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                active_q[j] <= RST_VAL;
            else if (commit)
                active_q[j] <= staged_q[j];
        end
    end

    assign active = active_q;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit && !soft_rst |=> $stable(active_q)); // R7

    AST_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_sel >= SEL_W'(SA_COUNT)) && !soft_rst |=> $stable(staged_q)); // R6
endmodule

// File: rtl/e1ts0_compose.sv
// Byte composer: builds the timeslot-zero byte for a given frame number.
// Pure combinational. Assumes frame_idx in 0..15 and crc_bits[3] = C1.
module e1ts0_compose
    import e1ts0_pkg::*;
(
    input  logic [FIDX_W-1:0] frame_idx,
    input  logic [3:0]        crc_bits,
    input  logic              a_bit,
    input  logic [1:0]        e_bits,
    input  sa_bank_t          sa_bank,
    output ts_byte_t          byte_out
);
    word_kind_e  kind;
    logic [2:0]  odd_k;
    logic [1:0]  crc_sel;
    logic        align_b1;
    logic        nonalign_b1;
    logic [SA_COUNT-1:0] sa_bits;

    assign kind    = word_kind_e'(frame_idx[0]);
    assign odd_k   = frame_idx[3:1];
    assign crc_sel = frame_idx[2:1];

    // Pick the CRC bit for an alignment frame (C1..C4 repeating).
    always_comb begin
        align_b1 = crc_bits[2'd3 - crc_sel];
    end

    // Pick bit 1 of a non-alignment frame: pattern, then E1, then E2.
    always_comb begin
        unique case (odd_k)
            3'd6:    nonalign_b1 = e_bits[1];
            3'd7:    nonalign_b1 = e_bits[0];
            default: nonalign_b1 = ODD_B1_LUT[3'd7 - odd_k];
        endcase
    end

    // Gather the national bits of this odd frame from each Sa lane.
    for (genvar j = 0; j < SA_COUNT; j++) begin : g_sa
        assign sa_bits[SA_COUNT-1-j] = sa_bank[j][3'd7 - odd_k];
    end

    // Assemble the final byte by word kind.
    always_comb begin
        if (kind == WORD_ALIGN)
            byte_out = {align_b1, ALIGN_TAIL};
        else
            byte_out = {nonalign_b1, 1'b1, a_bit, sa_bits};
    end
endmodule

// File: rtl/e1ts0_init_timer.sv
// Init timer: holds busy for FRAME_BITS bit strobes after reset or a
// soft reset request. Assumes bit_en is a one-cycle strobe.
module e1ts0_init_timer #(
    parameter int FRAME_BITS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic bit_en,
    output logic busy
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] START = CW'(FRAME_BITS);

    logic [CW-1:0] left_q;

    // Count down one frame of strobes, restarting on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            left_q <= START;
        else if (bit_en && left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    AST_BUSY_ENDS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_en)); // R9

    AST_SOFT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> busy); // R9
endmodule

// File: rtl/e1ts0_serializer.sv
// Serializer: loads a byte on a load strobe and shifts it out MSB first,
// one bit per bit_en. Idles at 1 with valid low. clear aborts at once.
module e1ts0_serializer
    import e1ts0_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear,
    input  logic     bit_en,
    input  logic     load,
    input  ts_byte_t byte_in,
    output logic     ser_q,
    output logic     valid
);
    localparam int CNT_W = $clog2(TS_BITS);

    ts_byte_t         shreg_q;
    logic [CNT_W-1:0] left_q;
    logic             ser_r;
    logic             valid_r;

    // Shift register, bit counter and output bit, all stepped by bit_en.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg_q <= '0;
            left_q  <= '0;
            ser_r   <= 1'b1;
            valid_r <= 1'b0;
        end else if (bit_en) begin
            if (load) begin
                ser_r   <= byte_in[TS_BITS-1];
                shreg_q <= {byte_in[TS_BITS-2:0], 1'b0};
                left_q  <= CNT_W'(TS_BITS - 1);
                valid_r <= 1'b1;
            end else if (left_q != '0) begin
                ser_r   <= shreg_q[TS_BITS-1];
                shreg_q <= {shreg_q[TS_BITS-2:0], 1'b0};
                left_q  <= left_q - 1'b1;
                valid_r <= 1'b1;
            end else begin
                ser_r   <= 1'b1;
                valid_r <= 1'b0;
            end
        end
    end

    assign ser_q = ser_r;
    assign valid = valid_r;

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en && !clear |=> $stable(ser_r) && $stable(valid_r)); // R3

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && load && !clear |=> valid_r && (ser_r == $past(byte_in[TS_BITS-1]))); // R2

    AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_r |-> ser_r); // R3
endmodule

// File: rtl/e1ts0_tx_gen.sv
// Top: E1 timeslot-zero transmit generator. Composes the per-frame byte,
// holds the national-bit buffer, times the one-frame reset period and
// serializes the byte. ais_n low forces ones straight to the line pin.
module e1ts0_tx_gen
    import e1ts0_pkg::*;
#(
    parameter int                    FRAME_BITS = 256,
    parameter logic [ODD_FRAMES-1:0] NB_RST_VAL = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  bit_en,
    input  logic                  ts0_start,
    input  logic [FIDX_W-1:0]     frame_idx,
    input  logic [3:0]            crc_bits,
    input  logic                  a_bit,
    input  logic [1:0]            e_bits,
    input  logic                  nb_wr_en,
    input  logic [SEL_W-1:0]      nb_wr_sel,
    input  logic [ODD_FRAMES-1:0] nb_wr_data,
    input  logic                  ais_n,
    output logic                  ser_out,
    output logic                  ts0_valid,
    output logic                  init_busy
);
    sa_bank_t sa_bank;
    ts_byte_t ts_byte;
    logic     load;
    logic     commit;
    logic     ser_q;

    // Accept a byte load only when the reset period is over.
    assign load   = bit_en && ts0_start && !init_busy && !soft_rst;
    assign commit = load && (frame_idx == '0);

    e1ts0_init_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .bit_en   (bit_en),
        .busy     (init_busy)
    );

    e1ts0_natbuf #(.RST_VAL(NB_RST_VAL)) u_natbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (nb_wr_en),
        .wr_sel   (nb_wr_sel),
        .wr_data  (nb_wr_data),
        .commit   (commit),
        .active   (sa_bank)
    );

    e1ts0_compose u_compose (
        .frame_idx (frame_idx),
        .crc_bits  (crc_bits),
        .a_bit     (a_bit),
        .e_bits    (e_bits),
        .sa_bank   (sa_bank),
        .byte_out  (ts_byte)
    );

    e1ts0_serializer u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (soft_rst),
        .bit_en  (bit_en),
        .load    (load),
        .byte_in (ts_byte),
        .ser_q   (ser_q),
        .valid   (ts0_valid)
    );

    // Line output with the alarm-indication override.
    assign ser_out = ser_q | ~ais_n;

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> !ts0_valid); // R9
endmodule

// File: tb/tb_e1ts0_tx_gen.sv
module tb_e1ts0_tx_gen;
    localparam int FB = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       bit_en = 1'b0;
    logic       ts0_start = 1'b0;
    logic [3:0] frame_idx = '0;
    logic [3:0] crc_bits = '0;
    logic       a_bit = 1'b0;
    logic [1:0] e_bits = '0;
    logic       nb_wr_en = 1'b0;
    logic [2:0] nb_wr_sel = '0;
    logic [7:0] nb_wr_data = '0;
    logic       ais_n = 1'b0;
    logic       ser_out, ts0_valid, init_busy;

    always #5 clk = ~clk;

    e1ts0_tx_gen #(.FRAME_BITS(FB)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_en(bit_en),
        .ts0_start(ts0_start), .frame_idx(frame_idx), .crc_bits(crc_bits),
        .a_bit(a_bit), .e_bits(e_bits), .nb_wr_en(nb_wr_en),
        .nb_wr_sel(nb_wr_sel), .nb_wr_data(nb_wr_data), .ais_n(ais_n),
        .ser_out(ser_out), .ts0_valid(ts0_valid), .init_busy(init_busy)
    );

    int    tests = 0;
    int    fails = 0;
    bit    done  = 0;
    logic  q_bit[$];
    string q_tag[$];
    string sa_tag = "R4";

    logic [7:0] m_staged [5];
    logic [7:0] m_active [5];
    int         drv_strobes = 0;

    task automatic chk(input logic got, input logic exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_defaults();
        for (int j = 0; j < 5; j++) begin
            m_staged[j] = 8'hFF;
            m_active[j] = 8'hFF;
        end
    endtask

    // Expected byte built straight from the requirement text.
    function automatic logic [7:0] exp_byte(input int f);
        logic [7:0] b;
        int k;
        logic [5:0] pat;
        pat = 6'b001011;
        if (f % 2 == 0) begin
            b = {crc_bits[3 - ((f / 2) % 4)], 7'b0011011};
        end else begin
            k = (f - 1) / 2;
            if (f == 13)      b[7] = e_bits[1];
            else if (f == 15) b[7] = e_bits[0];
            else              b[7] = pat[5 - k];
            b[6] = 1'b1;
            b[5] = a_bit;
            for (int j = 0; j < 5; j++) b[4 - j] = m_active[j][7 - k];
        end
        return b;
    endfunction

    // Driver: one bit strobe followed by one idle clock; pushes expectations.
    task automatic strobe(input logic start, input int f);
        logic [7:0] b;
        @(negedge clk);
        bit_en = 1'b1;
        ts0_start = start;
        frame_idx = 4'(f);
        if (start && drv_strobes >= FB) begin
            if (f == 0) for (int j = 0; j < 5; j++) m_active[j] = m_staged[j];
            b = exp_byte(f);
            for (int i = 7; i >= 0; i--) begin
                q_bit.push_back(b[i]);
                if (f % 2 == 0)      q_tag.push_back("R1");
                else if (i == 7)     q_tag.push_back("R5");
                else if (i >= 5)     q_tag.push_back("R4");
                else                 q_tag.push_back(sa_tag);
            end
        end
        drv_strobes++;
        @(negedge clk);
        bit_en = 1'b0;
        ts0_start = 1'b0;
    endtask

    task automatic run_frame(input int f);
        for (int bp = 0; bp < FB; bp++) strobe(bp == 0, f);
    endtask

    task automatic nb_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        nb_wr_en = 1'b1; nb_wr_sel = sel; nb_wr_data = d;
        if (sel < 3'd5) m_staged[sel] = d;
        @(negedge clk);
        nb_wr_en = 1'b0;
    endtask

    // Monitor: samples 2 ns after each rising edge and pops the scoreboard.
    int   seen = 0;
    logic last_out;
    bit   have_last = 0;
    always @(posedge clk) begin
        #2;
        if (!done) begin
            if (!rst_n) begin
                seen = 0;
                have_last = 0;
                chk(ts0_valid, 1'b0, "R9 reset valid");
                chk(init_busy, 1'b1, "R9 reset busy");
                if (!ais_n) chk(ser_out, 1'b1, "R8 ais in reset");
            end else if (soft_rst) begin
                seen = 0;
                have_last = 0;
            end else if (bit_en) begin
                seen++;
                chk(init_busy, (seen < FB) ? 1'b1 : 1'b0, "R9 busy span");
                if (q_bit.size() > 0) begin
                    logic eb;
                    string tg;
                    eb = q_bit.pop_front();
                    tg = q_tag.pop_front();
                    chk(ts0_valid, 1'b1, "R2 valid");
                    if (ais_n) chk(ser_out, eb, tg);
                    else       chk(ser_out, 1'b1, "R8 ais ones");
                end else begin
                    chk(ts0_valid, 1'b0, "R3 idle valid");
                    chk(ser_out, 1'b1, "R3 idle ones");
                end
                last_out = ser_out;
                have_last = ais_n;
            end else begin
                if (have_last && ais_n) chk(ser_out, last_out, "R3 hold");
                have_last = ais_n;
                if (ais_n) last_out = ser_out;
            end
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_defaults();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        ais_n = 1'b1;
        drv_strobes = 0;

        // Multiframe A: defaults after reset (R10), mid-MF write deferred (R7).
        crc_bits = 4'b1010; a_bit = 1'b0; e_bits = 2'b01;
        sa_tag = "R10";
        for (int f = 0; f < 6; f++) run_frame(f);
        nb_write(3'd0, 8'hA5);
        nb_write(3'd4, 8'h3C);
        nb_write(3'd5, 8'h00);   // R6 out-of-range select
        sa_tag = "R7";
        for (int f = 6; f < 16; f++) run_frame(f);

        // Multiframe B: committed values, AIS over frames 8-9 (R8).
        crc_bits = 4'b0110; a_bit = 1'b1; e_bits = 2'b10;
        sa_tag = "R6";
        for (int f = 0; f < 8; f++) run_frame(f);
        @(negedge clk); ais_n = 1'b0;
        run_frame(8); run_frame(9);
        @(negedge clk); ais_n = 1'b1;
        nb_write(3'd1, 8'h5A);
        nb_write(3'd2, 8'h0F);
        nb_write(3'd3, 8'hF0);
        for (int f = 10; f < 16; f++) run_frame(f);

        // Multiframe C: all five lanes carry distinct patterns (R4, R5).
        crc_bits = 4'b1101; a_bit = 1'b0; e_bits = 2'b11;
        sa_tag = "R4";
        for (int f = 0; f < 16; f++) run_frame(f);

        // Soft reset: one quiet frame, buffers back to ones (R9, R10).
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        model_defaults();
        drv_strobes = 0;
        crc_bits = 4'b0011; a_bit = 1'b1; e_bits = 2'b00;
        sa_tag = "R10";
        for (int f = 0; f < 16; f++) run_frame(f);

        repeat (20) @(negedge clk);
        chk(q_bit.size() == 0, 1'b1, "R2 all bits sent");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule